// File: doc/BRIEF.md
# Level-Sensitive DMA Request Sequencer

This block serves one DMA channel whose transfers are started by an active-low external request line held at a level. While the channel is enabled and idle, the line is sampled on every rising clock edge. A low level latches a pending request. The block then raises a bus request and waits for the bus to be granted. The grant is the bus break at which the pending request is cleared. After the grant the block performs one read cycle at the source address, followed by one write cycle of the read data at the destination address. Each bus cycle lasts until the bus returns an acknowledge.

The external line is not looked at between the moment a request is latched and the acknowledge of its write cycle. A line held low therefore gives exactly one read-write pair per acceptance and never builds up a queue. After each write the source and destination addresses step by their programmed increments, and a transfer counter counts down. When the counter reaches zero the enable drops and a one-cycle done pulse is raised. Software programs the channel with a single configuration write strobe. A write with the enable bit clear stops the channel after the pair in flight has finished.

Top module: `dma_lvl_req_seq`

## Requirements
- R1: After reset, `bus_req_o`, `bus_rd_o`, `bus_wr_o`, `en_o` and `done_o` are all 0.
- R2: On an edge with `cfg_we_i` high while the block is idle, the block loads the addresses, step codes and count, and sets the enable to `cfg_en_i` AND (count not zero). The request line is not sampled on that edge. The first sample is taken on the next edge.
- R3: While enabled and idle, a low `ext_req_ni` sampled on an edge raises `bus_req_o` from the next cycle. The request stays held, with no read or write strobe, until a cycle with `bus_gnt_i` high.
- R4: A grant while a request is held clears the request. In the next cycle `bus_rd_o` is high at the source address until a cycle with `bus_ack_i`. After that, `bus_wr_o` is high at the destination address, driving the captured read data, until a cycle with `bus_ack_i`.
- R5: `ext_req_ni` is ignored from the latch until the write acknowledge. The cycle after that acknowledge, the block is idle, `bus_req_o` is low and sampling has resumed. A line held low yields one pair per acceptance.
- R6: After its cycle's acknowledge, each address steps by its 2-bit code: 00 or 10 keeps it, 01 adds one, 11 subtracts one, with wraparound.
- R7: Each write acknowledge decrements the count. The acknowledge that takes the count to zero clears `en_o` and makes `done_o` high for exactly the next cycle.
- R8: A configuration write with `cfg_en_i` low while the block is busy clears `en_o` and changes nothing else. A pair already in its read or write finishes. A request that is held and not yet granted is dropped once `en_o` is low, and `bus_req_o` falls in the next cycle.
- R9: An enabling write with a count of zero leaves `en_o` low, and the block does not respond to the request line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value written |
| cfg_src_i | input | AW | Source start address |
| cfg_dst_i | input | AW | Destination start address |
| cfg_cnt_i | input | CW | Number of read-write pairs |
| cfg_src_step_i | input | 2 | Source step code |
| cfg_dst_step_i | input | 2 | Destination step code |
| ext_req_ni | input | 1 | External transfer request, active low, level sensitive |
| bus_gnt_i | input | 1 | Bus grant |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_rdata_i | input | DW | Read data |
| bus_req_o | output | 1 | Bus request |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Write data |
| en_o | output | 1 | Channel enable flag |
| done_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Two events can land in the same cycle. The first pair is the write acknowledge and a request line that is still low: the bench holds the line low across whole transfers and checks that the next `bus_req_o` appears only after an idle cycle, never straight out of the write. The second pair is a disabling configuration write and a transfer in flight or a held request: the bench issues it during a read and again during a long grant wait. It then checks the write count, the address sequence and whether a read strobe ever appeared. A cycle-by-cycle behavioural model compares every output on every clock.

// File: rtl/dma_lvl_pkg.sv
package dma_lvl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_RSV  = 2'b10,
        STEP_DEC  = 2'b11
    } step_e;
endpackage

// File: rtl/dma_lvl_addr_step.sv
module dma_lvl_addr_step
    import dma_lvl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  step_e         step_i,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        unique case (step_i)
            STEP_INC: addr_o = addr_i + AW'(1);
            STEP_DEC: addr_o = addr_i - AW'(1);
            default:  addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_lvl_cnt_dec.sv
module dma_lvl_cnt_dec #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    assign cnt_o  = cnt_i - ONE;
    assign last_o = (cnt_i == ONE);
endmodule

// File: rtl/dma_lvl_req_seq.sv
module dma_lvl_req_seq
    import dma_lvl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_we_i,
    input  logic          cfg_en_i,
    input  logic [AW-1:0] cfg_src_i,
    input  logic [AW-1:0] cfg_dst_i,
    input  logic [CW-1:0] cfg_cnt_i,
    input  logic [1:0]    cfg_src_step_i,
    input  logic [1:0]    cfg_dst_step_i,
    input  logic          ext_req_ni,
    input  logic          bus_gnt_i,
    input  logic          bus_ack_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          bus_req_o,
    output logic          bus_rd_o,
    output logic          bus_wr_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          en_o,
    output logic          done_o
);
    localparam int NPTR = 2;
    localparam int PSRC = 0;
    localparam int PDST = 1;

    typedef struct packed {
        seq_state_e    st;
        logic          en;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        step_e         src_step;
        step_e         dst_step;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NPTR-1:0][AW-1:0] ptr_cur, ptr_nxt;
    step_e                   ptr_step [NPTR];
    logic [CW-1:0]           cnt_nxt;
    logic                    cnt_last;

    assign ptr_cur[PSRC]  = r_q.src;
    assign ptr_cur[PDST]  = r_q.dst;
    assign ptr_step[PSRC] = r_q.src_step;
    assign ptr_step[PDST] = r_q.dst_step;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_lvl_addr_step #(.AW(AW)) u_step (
            .addr_i (ptr_cur[g]),
            .step_i (ptr_step[g]),
            .addr_o (ptr_nxt[g])
        );
    end

    dma_lvl_cnt_dec #(.CW(CW)) u_cnt (
        .cnt_i  (r_q.cnt),
        .cnt_o  (cnt_nxt),
        .last_o (cnt_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st != ST_IDLE && cfg_we_i && !cfg_en_i) begin
            r_d.en = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (cfg_we_i) begin
                    r_d.en       = cfg_en_i && (cfg_cnt_i != '0);
                    r_d.src      = cfg_src_i;
                    r_d.dst      = cfg_dst_i;
                    r_d.cnt      = cfg_cnt_i;
                    r_d.src_step = step_e'(cfg_src_step_i);
                    r_d.dst_step = step_e'(cfg_dst_step_i);
                end else if (r_q.en && !ext_req_ni) begin
                    r_d.st = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!r_q.en) begin
                    r_d.st = ST_IDLE;
                end else if (bus_gnt_i) begin
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                if (bus_ack_i) begin
                    r_d.data = bus_rdata_i;
                    r_d.src  = ptr_nxt[PSRC];
                    r_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (bus_ack_i) begin
                    r_d.dst = ptr_nxt[PDST];
                    r_d.cnt = cnt_nxt;
                    r_d.st  = ST_IDLE;
                    if (cnt_last) begin
                        r_d.en   = 1'b0;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, src_step: STEP_HOLD, dst_step: STEP_HOLD, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req_o   = (r_q.st != ST_IDLE);
    assign bus_rd_o    = (r_q.st == ST_READ);
    assign bus_wr_o    = (r_q.st == ST_WRITE);
    assign bus_addr_o  = (r_q.st == ST_WRITE) ? r_q.dst : r_q.src;
    assign bus_wdata_o = r_q.data;
    assign en_o        = r_q.en;
    assign done_o      = r_q.done;
endmodule

// File: rtl/dma_lvl_req_seq_chk.sv
module dma_lvl_req_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          bus_gnt_i,
    input logic          bus_ack_i,
    input logic          bus_req_o,
    input logic          bus_rd_o,
    input logic          bus_wr_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          en_o,
    input logic          done_o
);
    logic held;
    assign held = bus_req_o && !bus_rd_o && !bus_wr_o;

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_rd_o && bus_wr_o)); // R4
    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_o || bus_wr_o) |-> bus_req_o); // R3
    AST_HELD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && en_o && !bus_gnt_i) |=> (bus_req_o && !bus_rd_o && !bus_wr_o)); // R3
    AST_GRANT_STARTS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && en_o && bus_gnt_i) |=> bus_rd_o); // R4
    AST_READ_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_o && !bus_ack_i) |=> (bus_rd_o && $stable(bus_addr_o))); // R4
    AST_READ_TO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_o && bus_ack_i) |=> bus_wr_o); // R4
    AST_WRITE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_o && bus_ack_i) |=> !bus_req_o); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_DONE_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !en_o); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_o && !bus_req_o) |=> !bus_req_o); // R9
    AST_DROP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && !en_o) |=> !bus_req_o); // R8
endmodule

bind dma_lvl_req_seq dma_lvl_req_seq_chk #(.AW(AW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_gnt_i  (bus_gnt_i),
    .bus_ack_i  (bus_ack_i),
    .bus_req_o  (bus_req_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wr_o   (bus_wr_o),
    .bus_addr_o (bus_addr_o),
    .en_o       (en_o),
    .done_o     (done_o)
);

// File: tb/dma_lvl_req_seq_bench.sv
module dma_lvl_req_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_en = 1'b0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic [1:0]    cfg_ss = '0, cfg_ds = '0;
    logic          req_n = 1'b1;
    logic          gnt = 1'b0, ack = 1'b0;
    logic [DW-1:0] rdata;
    logic          bus_req, bus_rd, bus_wr, en, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    int vectors = 0, errors = 0;
    int gnt_lat = 0, ack_lat = 0;
    int wr_seen = 0, rd_seen = 0, done_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rdata = addr ^ 16'h5A3C;

    dma_lvl_req_seq u_dma_lvl_req_seq (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
        .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt),
        .cfg_src_step_i(cfg_ss), .cfg_dst_step_i(cfg_ds), .ext_req_ni(req_n),
        .bus_gnt_i(gnt), .bus_ack_i(ack), .bus_rdata_i(rdata),
        .bus_req_o(bus_req), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
        .bus_addr_o(addr), .bus_wdata_o(wdata), .en_o(en), .done_o(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 waiting for grant, 2 reading, 3 writing
    int            m_ph = 0;
    bit            m_en = 0, m_done = 0;
    logic [AW-1:0] m_src = '0, m_dst = '0;
    int            m_ss = 0, m_ds = 0;
    int            m_cnt = 0;
    logic [DW-1:0] m_data = '0;

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input int code);
        if (code == 1) return a + 1'b1;
        if (code == 3) return a - 1'b1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_en = 0; m_done = 0; m_cnt = 0; m_data = '0;
        end else begin
            bit was_en;
            was_en = m_en;
            m_done = 0;
            if (bus_wr && ack) wr_seen++;
            if (bus_rd) rd_seen++;
            if (m_ph != 0 && cfg_we && !cfg_en) m_en = 0;
            case (m_ph)
                0: if (cfg_we) begin
                       m_en = cfg_en && (cfg_cnt != 0);
                       m_src = cfg_src; m_dst = cfg_dst; m_cnt = int'(cfg_cnt);
                       m_ss = int'(cfg_ss); m_ds = int'(cfg_ds);
                   end else if (was_en && !req_n) m_ph = 1;
                1: if (!was_en) m_ph = 0; else if (gnt) m_ph = 2;
                2: if (ack) begin m_data = rdata; m_src = stepped(m_src, m_ss); m_ph = 3; end
                default: if (ack) begin
                       m_dst = stepped(m_dst, m_ds);
                       m_cnt = m_cnt - 1;
                       if (m_cnt == 0) begin m_en = 0; m_done = 1; end
                       m_ph = 0;
                   end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_seen++;
            check(bus_req == (m_ph != 0), "R3 bus_req", int'(bus_req), int'(m_ph != 0));
            check(bus_rd == (m_ph == 2), "R4 bus_rd", int'(bus_rd), int'(m_ph == 2));
            check(bus_wr == (m_ph == 3), "R4 bus_wr", int'(bus_wr), int'(m_ph == 3));
            if (m_ph == 2) check(addr == m_src, "R6 source address", int'(addr), int'(m_src));
            if (m_ph == 3) begin
                check(addr == m_dst, "R6 destination address", int'(addr), int'(m_dst));
                check(wdata == m_data, "R4 write data", int'(wdata), int'(m_data));
            end
            check(en == m_en, "R7 enable", int'(en), int'(m_en));
            check(done == m_done, "R7 done", int'(done), int'(m_done));
        end
    end

    // Bus slave: grant and acknowledge after programmable latencies
    int  gcnt = 0, acnt = 0;
    bit  acked = 0;
    always @(negedge clk) begin
        #1;
        if (bus_rd || bus_wr) begin
            gnt = 1'b0; gcnt = 0;
            if (acked) acnt = 0;
            ack = (acnt >= ack_lat);
            acked = ack;
            acnt++;
        end else begin
            ack = 1'b0; acnt = 0; acked = 0;
            if (bus_req) begin gnt = (gcnt >= gnt_lat); gcnt++; end
            else begin gnt = 1'b0; gcnt = 0; end
        end
    end

    task automatic cfg_write(input bit e, input logic [AW-1:0] s, input logic [AW-1:0] d,
                             input int n, input logic [1:0] ss, input logic [1:0] ds);
        @(negedge clk); #2;
        cfg_we = 1'b1; cfg_en = e; cfg_src = s; cfg_dst = d;
        cfg_cnt = CW'(n); cfg_ss = ss; cfg_ds = ds;
        @(negedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #3;
    endtask

    task automatic run_all;
        int w0, r0;
        repeat (3) @(negedge clk);
        #3;
        check(!bus_req && !bus_rd && !bus_wr && !en && !done, "R1 reset outputs",
              int'({bus_req, bus_rd, bus_wr, en, done}), 0);
        rst_n = 1'b1;

        // Level held low through a whole enabling write and transfer
        req_n = 1'b0; gnt_lat = 0; ack_lat = 0;
        w0 = wr_seen;
        cfg_write(1'b1, 16'h0100, 16'h0200, 3, 2'b01, 2'b01);
        #1;
        check(!bus_req, "R2 no sample on enabling edge", int'(bus_req), 0);
        cycles(1);
        check(bus_req, "R3 request after first sample", int'(bus_req), 1);
        while (en || bus_req) cycles(1);
        check(wr_seen - w0 == 3, "R5 one pair per acceptance", wr_seen - w0, 3);
        check(done_seen == 1, "R7 single done pulse", done_seen, 1);

        // Slow grant and acknowledge, decrementing/holding steps, pulsed line
        req_n = 1'b1; gnt_lat = 3; ack_lat = 2;
        w0 = wr_seen;
        cfg_write(1'b1, 16'h0001, 16'h7000, 4, 2'b11, 2'b10);
        while (en) begin
            @(negedge clk); #2; req_n = 1'b0;
            @(negedge clk); #2; req_n = 1'b1;
            cycles(2);
        end
        while (bus_req) cycles(1);
        check(wr_seen - w0 == 4, "R6 stretched transfers completed", wr_seen - w0, 4);

        // Zero count leaves the channel off
        req_n = 1'b0; gnt_lat = 0; ack_lat = 0;
        cfg_write(1'b1, 16'h0010, 16'h0020, 0, 2'b01, 2'b01);
        cycles(5);
        check(!en && !bus_req, "R9 zero count ignored", int'({en, bus_req}), 0);

        // Disable during a read: pair finishes, new config fields ignored
        ack_lat = 4;
        w0 = wr_seen;
        cfg_write(1'b1, 16'h0300, 16'h0400, 10, 2'b01, 2'b00);
        while (!bus_rd) cycles(1);
        cfg_write(1'b0, 16'hFFFF, 16'hFFFF, 7, 2'b11, 2'b11);
        while (bus_req) cycles(1);
        cycles(4);
        check(wr_seen - w0 == 1, "R8 pair in flight completes", wr_seen - w0, 1);
        check(!en && !bus_req, "R8 idle after disable", int'({en, bus_req}), 0);

        // Disable while the request waits for grant
        gnt_lat = 20; ack_lat = 0;
        r0 = rd_seen;
        cfg_write(1'b1, 16'h0500, 16'h0600, 5, 2'b01, 2'b01);
        while (!bus_req) cycles(1);
        cfg_write(1'b0, 16'h0500, 16'h0600, 5, 2'b01, 2'b01);
        cycles(2);
        check(!bus_req, "R8 held request dropped", int'(bus_req), 0);
        check(rd_seen == r0, "R8 no read after drop", rd_seen - r0, 0);

        // Write ack and low line coincide: request must come back only after an idle cycle
        gnt_lat = 0;
        cfg_write(1'b1, 16'h0800, 16'h0900, 2, 2'b01, 2'b01);
        while (!bus_wr) cycles(1);
        while (bus_wr) cycles(1);
        check(!bus_req, "R5 idle cycle after write", int'(bus_req), 0);
        cycles(1);
        check(bus_req, "R5 acceptance resumed", int'(bus_req), 1);
        while (en || bus_req) cycles(1);
        req_n = 1'b1;
        cycles(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule